// File: doc/BRIEF.md
# Dual-Channel Interrupt Pending Dispatcher

This block services the shared interrupt of a two-channel serial controller. When started, it reads the controller's interrupt-pending register. That register is only reachable through channel A. The block then works through every set cause and reads the register again. It repeats this until a read shows no cause pending. Any vector the controller offers is ignored.

In each pass, channel A is handled completely before channel B. For any channel with at least one pending cause, the block first writes a clear-interrupt command to that channel. It then raises one service strobe per pending cause, in the order receive, status, transmit. Each strobe is held until its acknowledgement arrives. A flag records whether the scan found anything to do.

Each channel also has a soft-request latch that other logic sets. A separate deferred scan visits channel 0 and then channel 1. It clears each set latch, pulses a service strobe for that channel, and reports how many channels it serviced.

Top module: `dual_irq_dispatcher`

## Requirements
- R1: After reset:
  - `busy`, `handled`, `bus_req`, `svc_req`, `soft_svc`, `soft_pend` and `soft_count` are all zero.
  - `bus_ack` and `svc_ack` are treated as inputs only.
- R2: A hard scan starts on `start_hard` while idle.
  - It performs a read (`bus_we`=0, `bus_chan`=0, `bus_addr`=PEND_ADDR=3). Each read completes on `bus_ack`, with `bus_rdata` sampled in that cycle.
  - The scan repeats until a read returns zero in bits 5:0. The cycle after that read completes, `busy` is low.
- R3: Pending bits are laid out as follows: 5 = A receive, 4 = A transmit, 3 = A status, 2 = B receive, 1 = B transmit, 0 = B status. All channel A activity of a pass precedes any channel B activity.
- R4: A channel with any of its three bits set gets a clear write before any of its strobes. The write has `bus_we`=1, `bus_chan` set to the channel (A=0, B=1), `bus_addr`=CMD_ADDR=0 and `bus_wdata`=CLR_CMD=8'h38. A channel with no bits set gets no write.
- R5: For each pending cause, one strobe is raised on `svc_req[3*ch+k]`, where k is 0 for receive, 1 for status and 2 for transmit. Strobes are issued in ascending k, and only for set bits.
- R6: Only one of `bus_req` or a `svc_req` bit is active at a time. Each is held with stable fields until acknowledged. Bus requests are acknowledged by `bus_ack`; strobes are acknowledged by the matching `svc_ack` bit. Any acknowledgement latency yields the same sequence of operations.
- R7: `handled` is cleared when a hard scan starts. It is set if any read in that scan returned a nonzero bits 5:0 value.
- R8: Bits 7:6 of `bus_rdata` are ignored. For example, 8'hC0 ends the scan with `handled` low.
- R9: A high `soft_set[c]` sets the latch of channel c. The latch is visible on `soft_pend[c]` from the next cycle.
- R10: `start_soft` while idle runs the deferred scan. It visits channel 0 and then channel 1, one cycle each. A channel whose latch is set gets its latch cleared and a one-cycle `soft_svc[c]` pulse. `soft_count` ends equal to the number of channels serviced.
- R11: When `soft_set[c]` coincides with that latch's clear, the latch stays set.
- R12: `start_hard` and `start_soft` are ignored while `busy`. When both are high while idle, the hard scan runs and the soft latches are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_hard | input | 1 | Start a pending-register scan |
| start_soft | input | 1 | Start a deferred soft-request scan |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_chan | output | 1 | Target channel (0 = A, 1 = B) |
| bus_addr | output | 4 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | 8 | Read data |
| svc_req | output | 6 | Per-cause service strobes |
| svc_ack | input | 6 | Per-cause service-done acknowledgements |
| soft_set | input | 2 | Per-channel soft-request set |
| soft_svc | output | 2 | Deferred service pulse per channel |
| soft_pend | output | 2 | Soft-request latch state |
| soft_count | output | 2 | Channels serviced by last deferred scan |
| busy | output | 1 | A scan is in progress |
| handled | output | 1 | Last hard scan found pending causes |

## Verification
The hard scan is tried with several pending patterns:
- A single cause on channel A.
- All six causes at once, which exposes order errors between channels and within a channel.
- Channel B alone, which shows whether a channel with nothing pending still gets a clear.
- A multi-pass sequence under delayed acknowledgements, which separates the loop-until-zero rule from a single pass and tests strobe holding.

Zero reads and reads with only the two top bits set tell a correct `handled` from one that ignores the cause mask. For deferred scans, the bench uses both latches set, only channel 1 set, and a set that coincides with the clear. These patterns separate visit order, count and set priority. Starts issued during a busy scan, and simultaneous starts, show whether either start is ignored or takes priority as required.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int NCH     = 2;
    localparam int CPC     = 3;
    localparam int NPEND   = NCH * CPC;
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CAUSE_W = $clog2(CPC);
    localparam int CNT_W   = $clog2(NCH + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_CHAN,
        S_CLEAR,
        S_CAUSE,
        S_SOFT
    } scan_state_t;

    typedef struct packed {
        scan_state_t         state;
        logic [CH_W-1:0]     ch;
        logic [CAUSE_W-1:0]  cause;
        logic [NPEND-1:0]    pend;
        logic                handled;
        logic [CH_W-1:0]     sidx;
        logic [CNT_W-1:0]    scnt;
    } scan_regs_t;
endpackage

// File: rtl/irqd_cause_map.sv
module irqd_cause_map
    import irqd_pkg::*;
(
    input  logic [NPEND-1:0]   pend,
    input  logic [CH_W-1:0]    ch,
    input  logic [CAUSE_W-1:0] cause,
    output logic               cur_bit,
    output logic               chan_any
);
    logic [NPEND-1:0] ordered;
    logic [NCH-1:0]   any_set;

    // Channel c occupies pend[base+2:base], base counted from the top;
    // ordered[] lists each channel's causes as receive, status, transmit.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int BASE = (NCH - 1 - c) * CPC;
        assign ordered[c*CPC + 0] = pend[BASE + 2];
        assign ordered[c*CPC + 1] = pend[BASE + 0];
        assign ordered[c*CPC + 2] = pend[BASE + 1];
        assign any_set[c]         = |pend[BASE +: CPC];
    end

    always_comb begin
        cur_bit  = ordered[int'(ch) * CPC + int'(cause)];
        chan_any = any_set[ch];
    end
endmodule

// File: rtl/irqd_softreq.sv
module irqd_softreq
    import irqd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] pend_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_latch
        logic req_d, req_q;

        always_comb begin
            req_d = set_i[c] | (req_q & ~clr_i[c]);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= req_d;
        end

        assign pend_o[c] = req_q;

        p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[c] |=> pend_o[c]);
    end
endmodule

// File: rtl/irqd_scan_fsm.sv
module irqd_scan_fsm
    import irqd_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 4,
    parameter int          PEND_ADDR = 3,
    parameter int          CMD_ADDR  = 0,
    parameter logic [7:0]  CLR_CMD   = 8'h38
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_hard,
    input  logic               start_soft,
    input  logic               bus_ack,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic [NPEND-1:0]   svc_ack,
    input  logic               cur_bit,
    input  logic               chan_any,
    input  logic [NCH-1:0]     soft_pend,
    output logic               bus_req,
    output logic               bus_we,
    output logic [CH_W-1:0]    bus_chan,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic [NPEND-1:0]   svc_req,
    output logic [NCH-1:0]     soft_clr,
    output logic [NCH-1:0]     soft_svc,
    output logic [CNT_W-1:0]   soft_count,
    output logic               busy,
    output logic               handled,
    output logic [NPEND-1:0]   pend_o,
    output logic [CH_W-1:0]    ch_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam logic [CH_W-1:0]    LAST_CH    = CH_W'(NCH - 1);
    localparam logic [CAUSE_W-1:0] LAST_CAUSE = CAUSE_W'(CPC - 1);

    scan_regs_t r_q, r_d;
    int         idx;
    logic       cause_done;

    always_comb begin
        r_d        = r_q;
        idx        = int'(r_q.ch) * CPC + int'(r_q.cause);
        cause_done = !cur_bit || svc_ack[idx];
        case (r_q.state)
            S_IDLE: begin
                if (start_hard) begin
                    r_d.state   = S_READ;
                    r_d.handled = 1'b0;
                end else if (start_soft) begin
                    r_d.state = S_SOFT;
                    r_d.sidx  = '0;
                    r_d.scnt  = '0;
                end
            end
            S_READ: begin
                if (bus_ack) begin
                    r_d.pend = bus_rdata[NPEND-1:0];
                    if (bus_rdata[NPEND-1:0] == '0) begin
                        r_d.state = S_IDLE;
                    end else begin
                        r_d.handled = 1'b1;
                        r_d.ch      = '0;
                        r_d.state   = S_CHAN;
                    end
                end
            end
            S_CHAN: begin
                if (chan_any)              r_d.state = S_CLEAR;
                else if (r_q.ch == LAST_CH) r_d.state = S_READ;
                else                       r_d.ch    = r_q.ch + 1'b1;
            end
            S_CLEAR: begin
                if (bus_ack) begin
                    r_d.state = S_CAUSE;
                    r_d.cause = '0;
                end
            end
            S_CAUSE: begin
                if (cause_done) begin
                    if (r_q.cause != LAST_CAUSE) begin
                        r_d.cause = r_q.cause + 1'b1;
                    end else if (r_q.ch == LAST_CH) begin
                        r_d.state = S_READ;
                    end else begin
                        r_d.ch    = r_q.ch + 1'b1;
                        r_d.state = S_CHAN;
                    end
                end
            end
            S_SOFT: begin
                if (soft_pend[r_q.sidx]) r_d.scnt = r_q.scnt + 1'b1;
                if (r_q.sidx == LAST_CH) r_d.state = S_IDLE;
                else                     r_d.sidx  = r_q.sidx + 1'b1;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_req   = (r_q.state == S_READ) || (r_q.state == S_CLEAR);
        bus_we    = (r_q.state == S_CLEAR);
        bus_chan  = (r_q.state == S_CLEAR) ? r_q.ch : '0;
        bus_addr  = (r_q.state == S_CLEAR) ? ADDR_W'(CMD_ADDR) : ADDR_W'(PEND_ADDR);
        bus_wdata = (r_q.state == S_CLEAR) ? DATA_W'(CLR_CMD) : '0;
        svc_req   = (r_q.state == S_CAUSE && cur_bit) ? (NPEND'(1) << idx) : '0;
        soft_svc  = (r_q.state == S_SOFT) ? (soft_pend & (NCH'(1) << r_q.sidx)) : '0;
        soft_clr  = soft_svc;
        soft_count = r_q.scnt;
        busy      = (r_q.state != S_IDLE);
        handled   = r_q.handled;
        pend_o    = r_q.pend;
        ch_o      = r_q.ch;
        cause_o   = r_q.cause;
    end

    p_one_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(svc_req) <= 1) && !(bus_req && (svc_req != '0)));

    p_bus_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_chan));

    p_svc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((svc_req != '0) && ((svc_req & svc_ack) == '0)) |=> $stable(svc_req));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req && (svc_req == '0));

    p_read_chan_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> (bus_chan == '0));

    p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_req && !bus_ack) |=> busy);
endmodule

// File: rtl/dual_irq_dispatcher.sv
module dual_irq_dispatcher
    import irqd_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 4,
    parameter int          PEND_ADDR = 3,
    parameter int          CMD_ADDR  = 0,
    parameter logic [7:0]  CLR_CMD   = 8'h38
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_hard,
    input  logic               start_soft,
    output logic               bus_req,
    output logic               bus_we,
    output logic [CH_W-1:0]    bus_chan,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ack,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic [NPEND-1:0]   svc_req,
    input  logic [NPEND-1:0]   svc_ack,
    input  logic [NCH-1:0]     soft_set,
    output logic [NCH-1:0]     soft_svc,
    output logic [NCH-1:0]     soft_pend,
    output logic [CNT_W-1:0]   soft_count,
    output logic               busy,
    output logic               handled
);
    logic [NPEND-1:0]   pend_w;
    logic [CH_W-1:0]    ch_w;
    logic [CAUSE_W-1:0] cause_w;
    logic               cur_bit_w, chan_any_w;
    logic [NCH-1:0]     soft_clr_w;

    irqd_cause_map u_map (
        .pend     (pend_w),
        .ch       (ch_w),
        .cause    (cause_w),
        .cur_bit  (cur_bit_w),
        .chan_any (chan_any_w)
    );

    irqd_softreq u_soft (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (soft_set),
        .clr_i  (soft_clr_w),
        .pend_o (soft_pend)
    );

    irqd_scan_fsm #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .PEND_ADDR (PEND_ADDR),
        .CMD_ADDR  (CMD_ADDR),
        .CLR_CMD   (CLR_CMD)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_hard (start_hard),
        .start_soft (start_soft),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .svc_ack    (svc_ack),
        .cur_bit    (cur_bit_w),
        .chan_any   (chan_any_w),
        .soft_pend  (soft_pend),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_chan   (bus_chan),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .svc_req    (svc_req),
        .soft_clr   (soft_clr_w),
        .soft_svc   (soft_svc),
        .soft_count (soft_count),
        .busy       (busy),
        .handled    (handled),
        .pend_o     (pend_w),
        .ch_o       (ch_w),
        .cause_o    (cause_w)
    );
endmodule

// File: tb/sim_dual_irq_dispatcher.sv
module sim_dual_irq_dispatcher;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_hard = 1'b0, start_soft = 1'b0;
    logic       bus_req, bus_we, bus_ack = 1'b0;
    logic [0:0] bus_chan;
    logic [3:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata = 8'h00;
    logic [5:0] svc_req, svc_ack = 6'h00;
    logic [1:0] soft_set = 2'b00, soft_svc, soft_pend, soft_count;
    logic       busy, handled;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_irq_dispatcher u0 (
        .clk(clk), .rst_n(rst_n), .start_hard(start_hard), .start_soft(start_soft),
        .bus_req(bus_req), .bus_we(bus_we), .bus_chan(bus_chan), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .svc_req(svc_req), .svc_ack(svc_ack), .soft_set(soft_set), .soft_svc(soft_svc),
        .soft_pend(soft_pend), .soft_count(soft_count), .busy(busy), .handled(handled)
    );

    int    n_vec = 0, n_bad = 0, cyc = 0, dly = 0, wait_cnt = 0;
    int    rd_q[$];
    int    exp_q[$];
    string tag = "R1";
    logic  mirror_set = 1'b0;
    logic [1:0] man_set = 2'b00;

    task automatic check(input string t, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic log_ev(input int e);
        if (exp_q.size() == 0) check(tag, e, -1);
        else                   check(tag, e, exp_q.pop_front());
    endtask

    // Reference model of one pass: read event (100), then per channel clear (200+ch)
    // and strobes (3*ch+k) with k: 0 receive, 1 status, 2 transmit.
    task automatic add_pass(input int v);
        rd_q.push_back(v);
        exp_q.push_back(100);
        if ((v & 'h38) != 0) begin
            exp_q.push_back(200);
            if (v & 'h20) exp_q.push_back(0);
            if (v & 'h08) exp_q.push_back(1);
            if (v & 'h10) exp_q.push_back(2);
        end
        if ((v & 'h07) != 0) begin
            exp_q.push_back(201);
            if (v & 'h04) exp_q.push_back(3);
            if (v & 'h01) exp_q.push_back(4);
            if (v & 'h02) exp_q.push_back(5);
        end
    endtask

    task automatic summary_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog %s actual=%0d expected=0", tag, cyc);
            summary_and_end();
        end
        if (rst_n) begin
            if (bus_req && wait_cnt >= dly) begin
                bus_ack  = 1'b1;
                wait_cnt = 0;
                if (!bus_we) begin
                    check("R2 read addr", int'(bus_addr), 3);
                    bus_rdata = (rd_q.size() != 0) ? 8'(rd_q.pop_front()) : 8'h00;
                    log_ev(100);
                end else begin
                    check("R4 clear data", int'(bus_wdata), 'h38);
                    check("R4 clear addr", int'(bus_addr), 0);
                    log_ev(200 + int'(bus_chan));
                end
            end else begin
                bus_ack = 1'b0;
                if (bus_req) wait_cnt++;
            end
            if (svc_req != 0 && wait_cnt >= dly) begin
                svc_ack  = svc_req;
                wait_cnt = 0;
                log_ev($clog2(svc_req));
            end else begin
                svc_ack = 6'h00;
                if (svc_req != 0) wait_cnt++;
            end
            if (soft_svc != 0) log_ev(300 + $clog2(soft_svc));
            soft_set = man_set | (mirror_set ? soft_svc : 2'b00);
        end
    end

    task automatic pulse(input logic h, input logic s);
        @(negedge clk);
        start_hard = h; start_soft = s;
        @(negedge clk);
        start_hard = 1'b0; start_soft = 1'b0;
    endtask

    task automatic finish_scan(input string t);
        while (busy) @(negedge clk);
        check({t, " expected events consumed"}, exp_q.size(), 0);
    endtask

    task automatic go_hard(input string t, input int exp_h);
        tag = t;
        pulse(1'b1, 1'b0);
        finish_scan(t);
        check("R7 handled", int'(handled), exp_h);
    endtask

    task automatic go_soft(input string t, input int exp_cnt, input int exp_pend);
        tag = t;
        pulse(1'b0, 1'b1);
        finish_scan(t);
        check("R10 soft_count", int'(soft_count), exp_cnt);
        check({t, " soft_pend"}, int'(soft_pend), exp_pend);
    endtask

    task automatic set_soft(input logic [1:0] m);
        @(negedge clk); man_set = m;
        @(negedge clk); man_set = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 handled", int'(handled), 0);
        check("R1 bus_req", int'(bus_req), 0);
        check("R1 svc_req", int'(svc_req), 0);
        check("R1 soft_pend", int'(soft_pend), 0);
        check("R1 soft_count", int'(soft_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        add_pass('h20); add_pass(0);
        go_hard("R5 single A receive", 1);

        add_pass('h3F); add_pass(0);
        go_hard("R3 all causes", 1);

        add_pass('h03); add_pass(0);
        go_hard("R4 channel B only", 1);

        dly = 2;
        add_pass('h09); add_pass('h12); add_pass('h24); add_pass(0);
        go_hard("R6 delayed multi-pass", 1);
        dly = 0;

        add_pass(0);
        go_hard("R7 empty scan", 0);

        add_pass('hC0);
        go_hard("R8 top bits only", 0);

        // 0xC4: only B receive counts; model masks with bits 5:0
        rd_q.push_back('hC4); exp_q.push_back(100); exp_q.push_back(201); exp_q.push_back(3);
        add_pass(0);
        go_hard("R8 masked B receive", 1);

        set_soft(2'b11);
        check("R9 soft_pend both", int'(soft_pend), 3);
        exp_q.push_back(300); exp_q.push_back(301);
        go_soft("R10 both latches", 2, 0);

        set_soft(2'b10);
        check("R9 soft_pend ch1", int'(soft_pend), 2);
        exp_q.push_back(301);
        go_soft("R10 channel 1 only", 1, 0);

        set_soft(2'b01);
        mirror_set = 1'b1;
        exp_q.push_back(300);
        go_soft("R11 set beats clear", 1, 1);
        mirror_set = 1'b0;
        @(negedge clk);
        exp_q.push_back(300);
        go_soft("R11 later clear", 1, 0);

        // R12: starts while busy are ignored
        set_soft(2'b01);
        dly = 3;
        tag = "R12 busy starts";
        add_pass('h20); add_pass(0);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        pulse(1'b0, 1'b1);
        finish_scan("R12 busy starts");
        dly = 0;
        check("R12 soft_pend untouched", int'(soft_pend), 1);
        check("R12 soft_count untouched", int'(soft_count), 1);

        // R12: simultaneous starts while idle, hard wins
        tag = "R12 both starts";
        add_pass('h01); add_pass(0);
        pulse(1'b1, 1'b1);
        finish_scan("R12 both starts");
        check("R12 soft_pend after hard", int'(soft_pend), 1);
        check("R12 handled", int'(handled), 1);

        repeat (3) @(negedge clk);
        check("R2 idle after scans", int'(busy), 0);
        summary_and_end();
    end
endmodule